// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits beside the shift and sequencing logic of a serial SRAM target that runs on an internal system clock. The serial clock, chip select and active-low pause line arrive as inputs that the system clock samples. From them the block works out whether the current transfer is suspended. It then gives the datapath two things. The first is a `pause_o` qualifier. The second is a pair of serial-clock edge strobes that are already suppressed while the transfer is suspended. A datapath that advances only on those strobes therefore keeps its bit count and sequence state through a pause without any further logic.

A pause starts or ends only while the serial clock is sampled low. If the pause line changes while the serial clock is high, the change waits for the next falling edge. The output-enable override `so_hiz_o` works differently. It follows the pause line combinationally in both directions, whatever the serial clock level. The function is disabled in four-bit mode, and the pause line has no effect while the device is deselected.

The controller has three states. IDLE means deselected. ACTIVE means a transfer is running. PAUSED means a transfer is suspended. The transitions are:
- select: IDLE to ACTIVE, when chip select is low.
- freeze: ACTIVE to PAUSED, when the pause line is low, the serial clock is low and four-bit mode is off.
- thaw: PAUSED to ACTIVE, when the pause line is high and the serial clock is low, or when four-bit mode is on.
- release: any state to IDLE, whenever chip select is high.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After reset, `pause_o`, `rise_o` and `fall_o` are 0 and the controller is in IDLE.
- R2: In ACTIVE, with the pause line low, the serial clock sampled low and four-bit mode off, `pause_o` is 1 after the next system clock edge.
- R3: While the serial clock is sampled high, a low pause line does not raise `pause_o`. The pause starts at the first edge where the serial clock is sampled low.
- R4: In PAUSED, with the pause line high and the serial clock sampled low, `pause_o` is 0 after the next system clock edge.
- R5: In PAUSED, while the serial clock is sampled high, a high pause line does not clear `pause_o`. The pause ends at the first edge where the serial clock is sampled low.
- R6: `rise_o` and `fall_o` stay 0 while paused, whatever the serial clock does. This includes the falling edge at which a pause starts or ends.
- R7: `so_hiz_o` is 1 exactly when chip select is low, the pause line is low and four-bit mode is off. It changes in the same cycle as those inputs, at any serial clock level.
- R8: Chip select high clears `pause_o` after the next edge. While chip select is high, the pause line causes no pause and `so_hiz_o` stays 0.
- R9: With four-bit mode on, the pause line has no effect on `pause_o` or `so_hiz_o`. Turning four-bit mode on during a pause clears `pause_o` after the next edge.
- R10: In ACTIVE and not pausing, a sampled 0-to-1 change of the serial clock gives a one-cycle `rise_o` pulse after that edge. A sampled 1-to-0 change gives a one-cycle `fall_o` pulse after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock level, sampled by clk_i |
| hold_n_i | input | 1 | Pause request, active low |
| quad_i | input | 1 | Four-bit mode active; disables the pause function |
| pause_o | output | 1 | Transfer suspended (state PAUSED) |
| rise_o | output | 1 | Qualified serial clock rising strobe |
| fall_o | output | 1 | Qualified serial clock falling strobe |
| so_hiz_o | output | 1 | Force the serial output to high impedance |

## Verification
`so_hiz_o` is combinational, so its result is due in the same cycle as the stimulus. The bench checks it a time step after each input change, before any clock edge. `pause_o`, `rise_o` and `fall_o` are due one system clock after the inputs that cause them. The bench changes inputs on falling clock edges and compares all outputs against its behavioural model 2 ns after every rising edge. Directed checks of the deferred entry and exit cases confirm that `pause_o` has not moved while the serial clock is high, and that it moves exactly one edge after the serial clock is driven low.

// File: rtl/hold_pause_pkg.sv
package hold_pause_pkg;
    typedef enum logic [1:0] {
        HP_IDLE   = 2'd0,
        HP_ACTIVE = 2'd1,
        HP_PAUSED = 2'd2
    } hp_state_e;
endpackage

// File: rtl/hold_sck_edge.sv
module hold_sck_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sck_i,
    output logic rise_raw_o,
    output logic fall_raw_o
);
    logic sck_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sck_q <= 1'b0;
        else          sck_q <= sck_i;
    end

    assign rise_raw_o = sck_i & ~sck_q;
    assign fall_raw_o = ~sck_i & sck_q;
endmodule

// File: rtl/hold_pause_fsm.sv
module hold_pause_fsm
    import hold_pause_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sel_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    input  logic quad_i,
    input  logic rise_raw_i,
    input  logic fall_raw_i,
    output logic pause_o,
    output logic rise_o,
    output logic fall_o
);
    hp_state_e state_q, state_d;
    logic      run_keep;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (sel_n_i) begin
            state_d = HP_IDLE;
        end else begin
            unique case (state_q)
                HP_IDLE:   state_d = HP_ACTIVE;
                HP_ACTIVE: if (!hold_n_i && !quad_i && !sck_i) state_d = HP_PAUSED;
                HP_PAUSED: if (quad_i || (hold_n_i && !sck_i)) state_d = HP_ACTIVE;
                default:   state_d = HP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= HP_IDLE;
        else          state_q <= state_d;
    end

    assign run_keep = (state_q == HP_ACTIVE) && (state_d == HP_ACTIVE);

    // output process
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            rise_o <= run_keep & rise_raw_i;
            fall_o <= run_keep & fall_raw_i;
        end
    end

    assign pause_o = (state_q == HP_PAUSED);

    // R2
    freeze_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == HP_ACTIVE && !sel_n_i && !hold_n_i && !quad_i && !sck_i) |=> (state_q == HP_PAUSED));
    // R5
    no_thaw_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == HP_PAUSED && !sel_n_i && !quad_i && sck_i) |=> (state_q == HP_PAUSED));
    // R3
    no_freeze_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != HP_PAUSED && sck_i) |=> (state_q != HP_PAUSED));
    // R8
    release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sel_n_i |=> (state_q == HP_IDLE));
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sel_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    input  logic quad_i,
    output logic pause_o,
    output logic rise_o,
    output logic fall_o,
    output logic so_hiz_o
);
    logic rise_raw, fall_raw;

    hold_sck_edge u_edge (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sck_i      (sck_i),
        .rise_raw_o (rise_raw),
        .fall_raw_o (fall_raw)
    );

    hold_pause_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sel_n_i    (sel_n_i),
        .sck_i      (sck_i),
        .hold_n_i   (hold_n_i),
        .quad_i     (quad_i),
        .rise_raw_i (rise_raw),
        .fall_raw_i (fall_raw),
        .pause_o    (pause_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o)
    );

    // tri-state override follows the pause line without a register
    assign so_hiz_o = ~sel_n_i & ~hold_n_i & ~quad_i;

    // R6
    frozen_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(pause_o && (rise_o || fall_o)));
    // R9
    quad_no_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (quad_i && !sel_n_i) |=> !pause_o);
endmodule

// File: tb/hold_pause_ctrl_test.sv
module hold_pause_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, hold_n = 1'b1, quad = 1'b0;
    logic pause_o, rise_o, fall_o, so_hiz_o;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference: 0 idle, 1 running, 2 suspended
    int  m_st = 0;
    bit  m_sckp = 0, m_rise = 0, m_fall = 0;

    always #4 clk = ~clk;

    hold_pause_ctrl uut (
        .clk_i(clk), .rst_n_i(rst_n), .sel_n_i(sel_n), .sck_i(sck),
        .hold_n_i(hold_n), .quad_i(quad),
        .pause_o(pause_o), .rise_o(rise_o), .fall_o(fall_o), .so_hiz_o(so_hiz_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_sckp = 0; m_rise = 0; m_fall = 0;
        end else begin
            int ns;
            ns = m_st;
            if (sel_n) ns = 0;
            else if (m_st == 0) ns = 1;
            else if (m_st == 1 && !hold_n && !quad && !sck) ns = 2;
            else if (m_st == 2 && (quad || (hold_n && !sck))) ns = 1;
            m_rise = (m_st == 1) && (ns == 1) && sck && !m_sckp;
            m_fall = (m_st == 1) && (ns == 1) && !sck && m_sckp;
            m_sckp = sck;
            m_st = ns;
        end
    end

    // per-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(pause_o == (m_st == 2), {cur_req, " pause"}, pause_o, m_st == 2);
            chk(rise_o == m_rise, {cur_req, " rise"}, rise_o, m_rise);
            chk(fall_o == m_fall, {cur_req, " fall"}, fall_o, m_fall);
            chk(so_hiz_o == (!sel_n && !hold_n && !quad), {cur_req, " hiz"},
                so_hiz_o, !sel_n && !hold_n && !quad);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive on a falling edge and check the combinational override right away
    task automatic drv(input bit s, input bit c, input bit h, input bit q);
        @(negedge clk);
        sel_n = s; sck = c; hold_n = h; quad = q;
        #1;
        chk(so_hiz_o == (!s && !h && !q), "R7 immediate hiz", so_hiz_o, !s && !h && !q);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (completion)");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        #1;
        chk(pause_o == 0 && rise_o == 0 && fall_o == 0, "R1 reset outputs", pause_o, 0);

        // R10 strobes in a running transfer
        cur_req = "R10";
        drv(0, 0, 1, 0); cyc(2);
        drv(0, 1, 1, 0);
        @(posedge clk); #2;
        chk(rise_o == 1, "R10 rise strobe", rise_o, 1);
        drv(0, 0, 1, 0);
        @(posedge clk); #2;
        chk(fall_o == 1, "R10 fall strobe", fall_o, 1);

        // R2 entry with serial clock low
        cur_req = "R2";
        drv(0, 0, 0, 0);
        @(posedge clk); #2;
        chk(pause_o == 1, "R2 pause at once", pause_o, 1);

        // R6 serial clock ignored while paused
        cur_req = "R6";
        for (int k = 0; k < 3; k++) begin
            drv(0, 1, 0, 0);
            @(posedge clk); #2;
            chk(rise_o == 0, "R6 no rise while paused", rise_o, 0);
            drv(0, 0, 0, 0);
            @(posedge clk); #2;
            chk(fall_o == 0, "R6 no fall while paused", fall_o, 0);
        end

        // R4 exit with serial clock low
        cur_req = "R4";
        drv(0, 0, 1, 0);
        @(posedge clk); #2;
        chk(pause_o == 0, "R4 resume at once", pause_o, 0);

        // R3 deferred entry
        cur_req = "R3";
        drv(0, 1, 1, 0); cyc(1);
        drv(0, 1, 0, 0);
        chk(so_hiz_o == 1, "R7 hiz with clock high", so_hiz_o, 1);
        cyc(3); #2;
        chk(pause_o == 0, "R3 entry deferred", pause_o, 0);
        drv(0, 0, 0, 0);
        @(posedge clk); #2;
        chk(pause_o == 1, "R3 entry at falling edge", pause_o, 1);
        chk(fall_o == 0, "R6 entry edge suppressed", fall_o, 0);

        // R5 deferred exit
        cur_req = "R5";
        drv(0, 1, 0, 0); cyc(1);
        drv(0, 1, 1, 0);
        chk(so_hiz_o == 0, "R7 drive with clock high", so_hiz_o, 0);
        cyc(3); #2;
        chk(pause_o == 1, "R5 exit deferred", pause_o, 1);
        drv(0, 0, 1, 0);
        @(posedge clk); #2;
        chk(pause_o == 0, "R5 exit at falling edge", pause_o, 0);
        chk(fall_o == 0, "R6 exit edge suppressed", fall_o, 0);

        // R8 deselect during pause, then pause line while deselected
        cur_req = "R8";
        drv(0, 0, 0, 0); cyc(2);
        drv(1, 0, 0, 0);
        @(posedge clk); #2;
        chk(pause_o == 0, "R8 deselect clears pause", pause_o, 0);
        chk(so_hiz_o == 0, "R8 no override while deselected", so_hiz_o, 0);
        cyc(3);

        // R9 four-bit mode
        cur_req = "R9";
        drv(0, 0, 1, 1); cyc(2);
        drv(0, 0, 0, 1);
        cyc(3); #2;
        chk(pause_o == 0, "R9 no pause in four-bit mode", pause_o, 0);
        chk(so_hiz_o == 0, "R9 no override in four-bit mode", so_hiz_o, 0);
        drv(0, 0, 0, 0);
        @(posedge clk); #2;
        chk(pause_o == 1, "R9 pause once mode off", pause_o, 1);
        drv(0, 1, 0, 1);
        @(posedge clk); #2;
        chk(pause_o == 0, "R9 mode on clears pause", pause_o, 0);

        drv(1, 0, 1, 0); cyc(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule